// File: doc/BRIEF.md
# ADC Ramp Pattern Checker

This block watches a pair of converter sample lanes, one in-phase (I) and one quadrature (Q), while the converter sends a counting test ramp. It reports for each lane whether it has locked onto the ramp and whether any sample has broken the ramp since then. Firmware uses it to find good capture timing. It sets a delay, restarts the checker, waits, and reads the flags. A lane that is locked and shows no error means the data were captured cleanly at that setting.

Each 16-bit lane carries a 14-bit sample justified to the top of the lane, so the two lowest lane bits are always zero. The I lane reaches the block with its sample bits inverted, and the block undoes that before it compares. Checking runs while the enable input is high. Dropping the enable and raising it again clears the results and starts a new check. Each lane also keeps a saturating count of its mismatched samples.

Top module: `adc_ramp_checker`

## Requirements
- R1: The I lane is bits 31:16 of `sample_word` and the Q lane is bits 15:0. In each lane the 14-bit sample sits in lane bits 15:2, so sample bit k is lane bit k+2, and lane bits 1:0 are expected to be zero.
- R2: Before any comparison, the I lane is corrected by XOR with 0xFFFC. The Q lane is used as received. A raw I value of 0xFFFC is therefore a zero sample, and a raw I value of 0x0000 is not.
- R3: A lane locks when its corrected 16-bit value is zero while the enable is high. Before a lane locks, no error is flagged and nothing is counted, whatever the samples are.
- R4: After lock, each sample is compared with the lane value {expected, 2'b00}. The expected sample starts at 1 and then rises by one per clock, wrapping from 0x3FFF to 0. Any difference, including nonzero bits 1:0, is a mismatch.
- R5: The expected value follows the ramp, not the received data, so a single corrupted sample in a clean ramp counts as exactly one mismatch.
- R6: Once set, ERROR and LOCKED stay set while the enable stays high, even if later samples match.
- R7: The two lanes are checked independently. A mismatch on one lane changes no output of the other.
- R8: In any clock where the enable is sampled low, the LOCKED flags, ERROR flags and counters of both lanes are zero after that edge, and input samples have no effect.
- R9: After a low-then-high sequence on the enable, a lane needs a new zero sample to lock. It starts with no error and a count of zero.
- R10: Each lane's mismatch counter is 16 bits wide, adds one per mismatch, and holds at 0xFFFF.
- R11: A sample presented in a clock cycle affects the outputs just after that cycle's rising edge, with one register stage of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chk_en | input | 1 | Checker enable; low clears the results, high runs the check |
| sample_word | input | 32 | I lane in bits 31:16, Q lane in bits 15:0 |
| i_locked | output | 1 | I lane has seen its zero sample |
| i_error | output | 1 | I lane has broken the ramp since lock (sticky) |
| i_err_cnt | output | 16 | I lane saturating mismatch count |
| q_locked | output | 1 | Q lane has seen its zero sample |
| q_error | output | 1 | Q lane has broken the ramp since lock (sticky) |
| q_err_cnt | output | 16 | Q lane saturating mismatch count |

## Verification
A clean ramp that runs through the 0x3FFF-to-0 wrap tests the increment and wrap logic on both lanes. A single corrupted Q sample shows whether the expected value follows the ramp or the received data, and whether the lanes are kept apart. It also shows whether the flag stays set once the data are clean again. A non-inverted ramp on the I lane, and a sample with a low bit set, check the inversion mask and the pad bits. Random values before lock, inputs while disabled, a restart, and a long run of bad samples that saturates the counter cover the lock rule, the clearing and the counter limit.

// File: rtl/ramp_chk_pkg.sv
package ramp_chk_pkg;

  // Number of lanes in one sample word; lane 1 (upper) is the inverted one.
  localparam int unsigned NUM_LANES = 2;
  localparam int unsigned INV_LANE  = 1;

  // Mask covering the sample field of a left-justified lane.
  function automatic int unsigned field_mask(int unsigned lane_w, int unsigned sample_w);
    return ((32'd1 << sample_w) - 32'd1) << (lane_w - sample_w);
  endfunction

endpackage

// File: rtl/ramp_lane_fix.sv
module ramp_lane_fix #(
  parameter int unsigned LANE_W   = 16,
  parameter int unsigned SAMPLE_W = 14,
  parameter bit          INVERT   = 1'b0
) (
  input  logic [LANE_W-1:0] raw_lane,
  output logic [LANE_W-1:0] fixed_lane
);

  localparam logic [LANE_W-1:0] MASK =
    LANE_W'(ramp_chk_pkg::field_mask(LANE_W, SAMPLE_W));

  generate
    if (INVERT) begin : g_inv
      // Undo the datapath inversion of the sample field; pad bits untouched.
      assign fixed_lane = raw_lane ^ MASK;
    end else begin : g_pass
      assign fixed_lane = raw_lane;
    end
  endgenerate

endmodule

// File: rtl/ramp_lane_chk.sv
module ramp_lane_chk #(
  parameter int unsigned LANE_W   = 16,
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_en,
  input  logic [LANE_W-1:0] lane,
  output logic              locked,
  output logic              error,
  output logic [CNT_W-1:0]  err_cnt
);

  localparam int unsigned PAD_W = LANE_W - SAMPLE_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic                locked_q, locked_d;
  logic                error_q,  error_d;
  logic [CNT_W-1:0]    cnt_q,    cnt_d;
  logic [SAMPLE_W-1:0] exp_q,    exp_d;

  logic [SAMPLE_W-1:0] exp_inc;
  logic [LANE_W-1:0]   exp_lane;
  logic                mismatch;
  logic                at_zero;

  // Next ramp value in the sample field, wrapping at the field width.
  assign exp_inc  = exp_q + 1'b1;
  assign exp_lane = {exp_inc, {PAD_W{1'b0}}};
  assign mismatch = (lane != exp_lane);
  assign at_zero  = (lane == '0);

  always_comb begin
    locked_d = locked_q;
    error_d  = error_q;
    cnt_d    = cnt_q;
    exp_d    = exp_q;
    if (!chk_en) begin
      locked_d = 1'b0;
      error_d  = 1'b0;
      cnt_d    = '0;
      exp_d    = '0;
    end else if (!locked_q) begin
      if (at_zero) begin
        locked_d = 1'b1;
        exp_d    = '0;
      end
    end else begin
      // Track the ideal ramp so one bad sample costs one mismatch.
      exp_d = exp_inc;
      if (mismatch) begin
        error_d = 1'b1;
        if (cnt_q != CNT_MAX) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      error_q  <= 1'b0;
      cnt_q    <= '0;
      exp_q    <= '0;
    end else begin
      locked_q <= locked_d;
      error_q  <= error_d;
      cnt_q    <= cnt_d;
      exp_q    <= exp_d;
    end
  end

  assign locked  = locked_q;
  assign error   = error_q;
  assign err_cnt = cnt_q;

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |=> (!locked_q && !error_q && (cnt_q == '0))); // R8

  AST_ERR_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    error_q |-> locked_q); // R3

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && error_q) |=> error_q); // R6

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && locked_q) |=> locked_q); // R6

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |=> (cnt_q >= $past(cnt_q))); // R10

  AST_CNT_MEANS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> error_q); // R6

endmodule

// File: rtl/adc_ramp_checker.sv
module adc_ramp_checker #(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned LANE_W   = 16,
  parameter int unsigned CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                chk_en,
  input  logic [2*LANE_W-1:0] sample_word,
  output logic                i_locked,
  output logic                i_error,
  output logic [CNT_W-1:0]    i_err_cnt,
  output logic                q_locked,
  output logic                q_error,
  output logic [CNT_W-1:0]    q_err_cnt
);

  import ramp_chk_pkg::*;

  logic rst_meta, rst_sync_n;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [NUM_LANES-1:0] lane_locked;
  logic [NUM_LANES-1:0] lane_error;
  logic [CNT_W-1:0]     lane_cnt [NUM_LANES];

  generate
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      logic [LANE_W-1:0] fixed;

      ramp_lane_fix #(
        .LANE_W   (LANE_W),
        .SAMPLE_W (SAMPLE_W),
        .INVERT   (g == INV_LANE)
      ) i_fix (
        .raw_lane   (sample_word[g*LANE_W +: LANE_W]),
        .fixed_lane (fixed)
      );

      ramp_lane_chk #(
        .LANE_W   (LANE_W),
        .SAMPLE_W (SAMPLE_W),
        .CNT_W    (CNT_W)
      ) i_chk (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .chk_en  (chk_en),
        .lane    (fixed),
        .locked  (lane_locked[g]),
        .error   (lane_error[g]),
        .err_cnt (lane_cnt[g])
      );
    end
  endgenerate

  assign i_locked  = lane_locked[INV_LANE];
  assign i_error   = lane_error[INV_LANE];
  assign i_err_cnt = lane_cnt[INV_LANE];
  assign q_locked  = lane_locked[0];
  assign q_error   = lane_error[0];
  assign q_err_cnt = lane_cnt[0];

endmodule

// File: tb/test_adc_ramp_checker.sv
`timescale 1ns/1ps
module test_adc_ramp_checker;

  logic        clk;
  logic        rst_n;
  logic        chk_en;
  logic [31:0] sample_word;
  logic        i_locked, i_error, q_locked, q_error;
  logic [15:0] i_err_cnt, q_err_cnt;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  adc_ramp_checker i_adc_ramp_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .chk_en      (chk_en),
    .sample_word (sample_word),
    .i_locked    (i_locked),
    .i_error     (i_error),
    .i_err_cnt   (i_err_cnt),
    .q_locked    (q_locked),
    .q_error     (q_error),
    .q_err_cnt   (q_err_cnt)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Bench-side encoding: I carries the inverted field, Q the plain field.
  function automatic logic [31:0] mk(input int iv, input int qv);
    logic [15:0] ir, qr;
    ir = {iv[13:0], 2'b00} ^ 16'hFFFC;
    qr = {qv[13:0], 2'b00};
    return {ir, qr};
  endfunction

  task automatic push(input logic en, input logic [31:0] w);
    @(negedge clk);
    chk_en      = en;
    sample_word = w;
    @(posedge clk);
    #1;
  endtask

  task automatic restart();
    push(1'b0, 32'h0);
    push(1'b0, 32'h0);
  endtask

  task automatic t_reset_state();
    check("R8 reset i_locked", i_locked, 0);
    check("R8 reset q_locked", q_locked, 0);
    check("R8 reset i_error",  i_error,  0);
    check("R8 reset q_error",  q_error,  0);
    check("R8 reset counts",   {i_err_cnt, q_err_cnt}, 0);
  endtask

  task automatic t_clean_ramp();
    restart();
    push(1'b1, mk(0, 0));
    check("R11 i lock right after zero edge", i_locked, 1);
    check("R11 q lock right after zero edge", q_locked, 1);
    for (int k = 1; k < 16384 + 6; k++) push(1'b1, mk(k % 16384, k % 16384));
    check("R4 clean ramp with wrap i_error", i_error, 0);
    check("R4 clean ramp with wrap q_error", q_error, 0);
    check("R1 clean ramp counts", {i_err_cnt, q_err_cnt}, 0);
  endtask

  task automatic t_prelock();
    restart();
    push(1'b1, mk(5, 9));
    push(1'b1, mk(123, 77));
    push(1'b1, 32'h1234_5678);
    check("R3 no lock before zero", {i_locked, q_locked}, 0);
    check("R3 no error before lock", {i_error, q_error}, 0);
    check("R3 no count before lock", {i_err_cnt, q_err_cnt}, 0);
    push(1'b1, mk(0, 0));
    check("R3 lock on zero", {i_locked, q_locked}, 2'b11);
  endtask

  task automatic t_glitch_and_sticky();
    restart();
    push(1'b1, mk(0, 0));
    push(1'b1, mk(1, 1));
    push(1'b1, mk(2, 2));
    push(1'b1, mk(3, 77));
    check("R11 q error right after bad edge", q_error, 1);
    for (int k = 4; k < 10; k++) push(1'b1, mk(k, k));
    check("R5 one bad sample counts once", q_err_cnt, 1);
    check("R7 i lane untouched error", i_error, 0);
    check("R7 i lane untouched count", i_err_cnt, 0);
    for (int k = 10; k < 30; k++) push(1'b1, mk(k, k));
    check("R6 error sticky", q_error, 1);
    check("R6 lock sticky", q_locked, 1);
    check("R6 count unchanged on clean data", q_err_cnt, 1);
  endtask

  task automatic t_inversion();
    restart();
    push(1'b1, {16'h0000, 16'h0000});
    check("R2 raw zero on I is not a lock", i_locked, 0);
    check("R1 Q locked from lower half", q_locked, 1);
    push(1'b1, {16'hFFFC, 16'h0004});
    check("R2 raw 0xFFFC on I locks", i_locked, 1);
    push(1'b1, {16'h0008, 16'h0008});
    check("R2 non-inverted I ramp flagged", i_error, 1);
    check("R2 Q plain ramp clean", q_error, 0);
  endtask

  task automatic t_pad_bits();
    restart();
    push(1'b1, mk(0, 0));
    push(1'b1, {mk(1, 0) | 32'h0000_0005});
    check("R4 nonzero pad bits flagged", q_error, 1);
    check("R4 pad mismatch counted", q_err_cnt, 1);
    check("R7 I lane clean", i_error, 0);
  endtask

  task automatic t_restart();
    push(1'b0, mk(0, 0));
    check("R8 disable clears flags", {i_locked, i_error, q_locked, q_error}, 0);
    check("R8 disable clears counts", {i_err_cnt, q_err_cnt}, 0);
    push(1'b0, mk(0, 0));
    push(1'b0, mk(0, 0));
    check("R8 zero while disabled ignored", {i_locked, q_locked}, 0);
    push(1'b1, mk(8, 8));
    check("R9 fresh check needs new zero", {i_locked, q_locked}, 0);
    check("R9 fresh check no error", {i_error, q_error}, 0);
    push(1'b1, mk(0, 0));
    check("R9 relock after restart", {i_locked, q_locked}, 2'b11);
  endtask

  task automatic t_saturate();
    restart();
    push(1'b1, mk(0, 0));
    for (int k = 1; k < 65541; k++) push(1'b1, {mk(k % 16384, 0)} | 32'h0000_0001);
    check("R10 counter saturates", q_err_cnt, 16'hFFFF);
    check("R10 error flag set", q_error, 1);
    check("R7 I lane clean during Q burst", i_err_cnt, 0);
  endtask

  initial begin
    #700_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n       = 1'b0;
    chk_en      = 1'b0;
    sample_word = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset_state();
    t_clean_ramp();
    t_prelock();
    t_glitch_and_sticky();
    t_inversion();
    t_pad_bits();
    t_restart();
    t_saturate();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule